// File: doc/BRIEF.md
# Shared-Private Buffer Admission Controller

This block makes the accept-or-drop decision for cells entering a shared-memory packet switch with `NUM_Q` output queues. It also keeps the occupancy accounting for that decision. The cell memory is divided into two kinds of region. Each queue owns a small reserved region that no other queue can touch. All queues can draw on one common pool, which holds whatever the reserved regions leave over. An arriving cell is charged to its own queue's reserved region while that region has room. Once the region is full, the cell is charged to the common pool. If the common pool is also full, the cell is refused.

The decision is combinational, so it is valid in the same cycle as the enqueue request. The counters update on the following clock edge. A departing cell gives its credit back to the common pool first, while the queue still holds any pool-charged cells. Only after that does it return credit to the queue's own reserved region. An enqueue and a dequeue may arrive in the same cycle, and both take effect. The cell data memory, the queue link storage and the scheduler are outside this block.

Top module: `buf_admit_ctrl`

## Requirements
- R1: After reset, every queue occupancy, every reserved-region count and the common-pool count read zero.
- R2: An enqueue to a queue whose reserved count is below `PRIV_CELLS` is accepted with `enq_region_o` = 1 (reserved). That queue's reserved count and occupancy rise by one on the next cycle.
- R3: An enqueue to a queue whose reserved region is full, while the pool holds fewer than `TOTAL_CELLS - NUM_Q*PRIV_CELLS` cells, is accepted with `enq_region_o` = 2 (pool). The pool count rises by one and no reserved count changes.
- R4: An enqueue to a queue whose reserved region is full, while the pool is also full, gives `enq_drop_o` = 1, `enq_accept_o` = 0 and `enq_region_o` = 0. No counter changes because of it.
- R5: A queue whose reserved region has room accepts its cell even when the pool is full and other queues are refusing cells.
- R6: A dequeue from a queue that holds pool-charged cells lowers the pool count and that queue's pool share by one, and leaves its reserved count unchanged. If the queue holds no pool-charged cells, the dequeue lowers its reserved count instead.
- R7: A dequeue naming an empty queue has no effect on any counter.
- R8: An enqueue and a dequeue in the same cycle are both applied. The admission decision uses the counter values from the start of that cycle, so a cell leaving in that cycle does not make room for the one arriving.
- R9: The pool count never exceeds `TOTAL_CELLS - NUM_Q*PRIV_CELLS`.
- R10: With `enq_valid_i` low, neither `enq_accept_o` nor `enq_drop_o` is asserted, and they are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Enqueue request this cycle |
| enq_qid_i | input | QW | Target queue of the enqueue |
| deq_valid_i | input | 1 | Dequeue request this cycle |
| deq_qid_i | input | QW | Source queue of the dequeue |
| enq_accept_o | output | 1 | Cell admitted (combinational) |
| enq_drop_o | output | 1 | Cell refused (combinational) |
| enq_region_o | output | 2 | Region charged: 0 none, 1 reserved, 2 pool |
| q_occ_o | output | NUM_Q*OW | Per-queue total cell count, queue i at bits i*OW |
| q_priv_o | output | NUM_Q*PW | Per-queue reserved-region count, queue i at bits i*PW |
| shared_used_o | output | SW | Cells currently charged to the pool |

## Verification
An admission and a release can fall in the same cycle, either on one queue or on two different queues. The bench produces this in three ways. It issues an enqueue and a dequeue together while the pool has a free slot. It issues them together while the pool is exactly full. It issues them together against an empty queue. It also mixes them at random for several hundred cycles. In every case the bench judges the combinational decision against a model that uses only the counters from the start of that cycle. It then checks the counters after the edge, which must show the enqueue and the shared-first release both applied.

// File: rtl/buf_admit_pkg.sv
package buf_admit_pkg;

  typedef enum logic [1:0] {
    REG_NONE   = 2'd0,
    REG_PRIV   = 2'd1,
    REG_SHARED = 2'd2
  } region_e;

endpackage

// File: rtl/q_account.sv
module q_account #(
  parameter int PRIV_CELLS = 4,
  parameter int PW         = 3,
  parameter int SW         = 5,
  parameter int OW         = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          add_priv_i,
  input  logic          add_shr_i,
  input  logic          rel_i,
  output logic          rel_shr_o,
  output logic [PW-1:0] priv_cnt_o,
  output logic [SW-1:0] shr_cnt_o,
  output logic [OW-1:0] occ_o
);

  logic [PW-1:0] priv_q;
  logic [SW-1:0] shr_q;
  logic          nonempty;
  logic          rel_priv;

  assign nonempty  = (priv_q != '0) || (shr_q != '0);
  // pool share is returned before the reserved share
  assign rel_shr_o = rel_i && (shr_q != '0);
  assign rel_priv  = rel_i && nonempty && (shr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q <= '0;
    end else if (add_priv_i && !rel_priv) begin
      priv_q <= priv_q + 1'b1;
    end else if (!add_priv_i && rel_priv) begin
      priv_q <= priv_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shr_q <= '0;
    end else if (add_shr_i && !rel_shr_o) begin
      shr_q <= shr_q + 1'b1;
    end else if (!add_shr_i && rel_shr_o) begin
      shr_q <= shr_q - 1'b1;
    end
  end

  assign priv_cnt_o = priv_q;
  assign shr_cnt_o  = shr_q;
  assign occ_o      = OW'(priv_q) + OW'(shr_q);

endmodule

// File: rtl/shared_pool.sv
module shared_pool #(
  parameter int SHARED_CELLS = 16,
  parameter int SW           = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [SW-1:0] used_o,
  output logic          full_o
);

  logic [SW-1:0] used_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q <= '0;
    end else if (inc_i && !dec_i) begin
      used_q <= used_q + 1'b1;
    end else if (!inc_i && dec_i) begin
      used_q <= used_q - 1'b1;
    end
  end

  assign used_o = used_q;
  assign full_o = (used_q >= SW'(SHARED_CELLS));

endmodule

// File: rtl/admit_decide.sv
module admit_decide
  import buf_admit_pkg::*;
#(
  parameter int NUM_Q      = 4,
  parameter int PRIV_CELLS = 4,
  parameter int QW         = 2,
  parameter int PW         = 3
) (
  input  logic               enq_valid_i,
  input  logic [QW-1:0]      enq_qid_i,
  input  logic [NUM_Q*PW-1:0] priv_flat_i,
  input  logic               shared_full_i,
  output region_e            region_o,
  output logic               accept_o,
  output logic               drop_o
);

  logic [PW-1:0] priv_sel;
  logic          qid_hit;

  always_comb begin
    priv_sel = '0;
    qid_hit  = 1'b0;
    for (int i = 0; i < NUM_Q; i++) begin
      if (enq_qid_i == QW'(i)) begin
        priv_sel = priv_flat_i[i*PW +: PW];
        qid_hit  = 1'b1;
      end
    end
    region_o = REG_NONE;
    if (enq_valid_i && qid_hit) begin
      if (priv_sel < PW'(PRIV_CELLS)) region_o = REG_PRIV;
      else if (!shared_full_i)        region_o = REG_SHARED;
    end
    accept_o = (region_o != REG_NONE);
    drop_o   = enq_valid_i && !accept_o;
  end

endmodule

// File: rtl/buf_admit_ctrl.sv
module buf_admit_ctrl
  import buf_admit_pkg::*;
#(
  parameter int NUM_Q       = 4,
  parameter int PRIV_CELLS  = 4,
  parameter int TOTAL_CELLS = 32,
  localparam int SHARED_CELLS = TOTAL_CELLS - NUM_Q*PRIV_CELLS,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int OW = $clog2(TOTAL_CELLS + 1),
  localparam int PW = $clog2(PRIV_CELLS + 1),
  localparam int SW = (SHARED_CELLS > 0) ? $clog2(SHARED_CELLS + 1) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enq_valid_i,
  input  logic [QW-1:0]       enq_qid_i,
  input  logic                deq_valid_i,
  input  logic [QW-1:0]       deq_qid_i,
  output logic                enq_accept_o,
  output logic                enq_drop_o,
  output logic [1:0]          enq_region_o,
  output logic [NUM_Q*OW-1:0] q_occ_o,
  output logic [NUM_Q*PW-1:0] q_priv_o,
  output logic [SW-1:0]       shared_used_o
);

  region_e          region;
  logic             accept;
  logic             shared_full;
  logic [NUM_Q-1:0] rel_shr;
  logic             pool_inc;
  logic             pool_dec;

  admit_decide #(
    .NUM_Q      (NUM_Q),
    .PRIV_CELLS (PRIV_CELLS),
    .QW         (QW),
    .PW         (PW)
  ) u_decide (
    .enq_valid_i   (enq_valid_i),
    .enq_qid_i     (enq_qid_i),
    .priv_flat_i   (q_priv_o),
    .shared_full_i (shared_full),
    .region_o      (region),
    .accept_o      (accept),
    .drop_o        (enq_drop_o)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic          sel_enq;
    logic [SW-1:0] shr_cnt;

    assign sel_enq = accept && (enq_qid_i == QW'(q));

    q_account #(
      .PRIV_CELLS (PRIV_CELLS),
      .PW         (PW),
      .SW         (SW),
      .OW         (OW)
    ) u_acct (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .add_priv_i (sel_enq && (region == REG_PRIV)),
      .add_shr_i  (sel_enq && (region == REG_SHARED)),
      .rel_i      (deq_valid_i && (deq_qid_i == QW'(q))),
      .rel_shr_o  (rel_shr[q]),
      .priv_cnt_o (q_priv_o[q*PW +: PW]),
      .shr_cnt_o  (shr_cnt),
      .occ_o      (q_occ_o[q*OW +: OW])
    );
  end

  assign pool_inc = accept && (region == REG_SHARED);
  assign pool_dec = |rel_shr;

  shared_pool #(
    .SHARED_CELLS (SHARED_CELLS),
    .SW           (SW)
  ) u_pool (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (pool_inc),
    .dec_i  (pool_dec),
    .used_o (shared_used_o),
    .full_o (shared_full)
  );

  assign enq_accept_o = accept;
  assign enq_region_o = region;

endmodule

// File: rtl/buf_admit_chk.sv
module buf_admit_chk #(
  parameter int NUM_Q        = 4,
  parameter int PRIV_CELLS   = 4,
  parameter int SHARED_CELLS = 16,
  parameter int QW           = 2,
  parameter int OW           = 6,
  parameter int PW           = 3,
  parameter int SW           = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                enq_valid_i,
  input logic [QW-1:0]       enq_qid_i,
  input logic                deq_valid_i,
  input logic [QW-1:0]       deq_qid_i,
  input logic                enq_accept_o,
  input logic                enq_drop_o,
  input logic [1:0]          enq_region_o,
  input logic [NUM_Q*OW-1:0] q_occ_o,
  input logic [NUM_Q*PW-1:0] q_priv_o,
  input logic [SW-1:0]       shared_used_o
);

  p_reset_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (shared_used_o == '0) && (q_occ_o == '0));

  p_pool_only_when_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_region_o == 2'd2) |-> (q_priv_o[enq_qid_i*PW +: PW] == PW'(PRIV_CELLS)));

  p_pool_grows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_region_o == 2'd2) && !deq_valid_i |=> shared_used_o == $past(shared_used_o) + 1'b1);

  p_drop_no_change_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_drop_o && !deq_valid_i |=> $stable(shared_used_o) && $stable(q_occ_o));

  p_empty_deq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_valid_i && !enq_valid_i && (q_occ_o[deq_qid_i*OW +: OW] == '0) |=> $stable(q_occ_o));

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shared_used_o <= SW'(SHARED_CELLS));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enq_valid_i |-> !enq_accept_o && !enq_drop_o);

  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(enq_accept_o && enq_drop_o));

endmodule

bind buf_admit_ctrl buf_admit_chk #(
  .NUM_Q        (NUM_Q),
  .PRIV_CELLS   (PRIV_CELLS),
  .SHARED_CELLS (SHARED_CELLS),
  .QW           (QW),
  .OW           (OW),
  .PW           (PW),
  .SW           (SW)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .enq_valid_i   (enq_valid_i),
  .enq_qid_i     (enq_qid_i),
  .deq_valid_i   (deq_valid_i),
  .deq_qid_i     (deq_qid_i),
  .enq_accept_o  (enq_accept_o),
  .enq_drop_o    (enq_drop_o),
  .enq_region_o  (enq_region_o),
  .q_occ_o       (q_occ_o),
  .q_priv_o      (q_priv_o),
  .shared_used_o (shared_used_o)
);

// File: tb/sim_buf_admit_ctrl.sv
`timescale 1ns/1ps
module sim_buf_admit_ctrl;

  localparam int NQ   = 4;
  localparam int PRIV = 4;
  localparam int TOT  = 32;
  localparam int SHR  = TOT - NQ*PRIV;
  localparam int QW   = 2;
  localparam int OW   = 6;
  localparam int PW   = 3;
  localparam int SW   = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic enq_valid = 1'b0, deq_valid = 1'b0;
  logic [QW-1:0] enq_qid = '0, deq_qid = '0;
  logic enq_accept, enq_drop;
  logic [1:0] enq_region;
  logic [NQ*OW-1:0] q_occ;
  logic [NQ*PW-1:0] q_priv;
  logic [SW-1:0] shared_used;

  always #4 clk = ~clk;

  buf_admit_ctrl #(.NUM_Q(NQ), .PRIV_CELLS(PRIV), .TOTAL_CELLS(TOT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .enq_valid_i(enq_valid), .enq_qid_i(enq_qid),
    .deq_valid_i(deq_valid), .deq_qid_i(deq_qid),
    .enq_accept_o(enq_accept), .enq_drop_o(enq_drop), .enq_region_o(enq_region),
    .q_occ_o(q_occ), .q_priv_o(q_priv), .shared_used_o(shared_used)
  );

  typedef struct {
    string            req;
    logic [3:0]       dec;
    logic [NQ*OW-1:0] occ;
    logic [NQ*PW-1:0] prv;
    logic [SW-1:0]    used;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0;
  bit done = 0;
  int m_priv[NQ], m_shr[NQ], m_used;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the model's prediction
  task automatic step(input string req, input bit ev, input int eq, input bit dv, input int dq);
    exp_t e;
    bit acc = 0, drp = 0;
    logic [1:0] rgn = 2'd0;
    @(negedge clk);
    enq_valid = ev; enq_qid = QW'(eq);
    deq_valid = dv; deq_qid = QW'(dq);
    if (ev) begin
      if (m_priv[eq] < PRIV)   begin acc = 1; rgn = 2'd1; end
      else if (m_used < SHR)   begin acc = 1; rgn = 2'd2; end
      else                     drp = 1;
    end
    if (dv && (m_priv[dq] + m_shr[dq]) > 0) begin
      if (m_shr[dq] > 0) begin m_shr[dq]--; m_used--; end
      else m_priv[dq]--;
    end
    if (rgn == 2'd1) m_priv[eq]++;
    if (rgn == 2'd2) begin m_shr[eq]++; m_used++; end
    e.req = req;
    e.dec = {acc, drp, rgn};
    for (int q = 0; q < NQ; q++) begin
      e.occ[q*OW +: OW] = OW'(m_priv[q] + m_shr[q]);
      e.prv[q*PW +: PW] = PW'(m_priv[q]);
    end
    e.used = SW'(m_used);
    exp_q.push_back(e);
  endtask

  // monitor: decision mid-cycle, counters after the edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() != 0) begin
        chk(exp_q[0].req, "decision", 32'({enq_accept, enq_drop, enq_region}), 32'(exp_q[0].dec));
        @(posedge clk);
        #2;
        chk(exp_q[0].req, "q_occ", 32'(q_occ), 32'(exp_q[0].occ));
        chk(exp_q[0].req, "q_priv", 32'(q_priv), 32'(exp_q[0].prv));
        chk(exp_q[0].req, "pool", 32'(shared_used), 32'(exp_q[0].used));
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int q = 0; q < NQ; q++) begin m_priv[q] = 0; m_shr[q] = 0; end
    m_used = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #2;
    chk("R1", "q_occ", 32'(q_occ), 0);
    chk("R1", "q_priv", 32'(q_priv), 0);
    chk("R1", "pool", 32'(shared_used), 0);
    chk("R10", "idle outputs", 32'({enq_accept, enq_drop, enq_region}), 0);

    step("R10", 0, 0, 0, 0);
    for (int i = 0; i < PRIV; i++) step("R2", 1, 0, 0, 0);
    for (int i = 0; i < SHR; i++)  step("R3", 1, 0, 0, 0);
    step("R4", 1, 0, 0, 0);
    step("R5", 1, 1, 0, 0);
    for (int i = 0; i < PRIV; i++) step("R5", 1, 2, 0, 0);
    step("R4", 1, 2, 0, 0);
    step("R6", 0, 0, 1, 0);
    step("R8", 1, 0, 1, 0);
    step("R3", 1, 0, 0, 0);
    step("R8", 1, 0, 1, 0);
    step("R7", 0, 0, 1, 3);
    step("R6", 0, 0, 1, 1);
    step("R8", 1, 1, 1, 1);
    step("R7", 0, 0, 1, 3);
    for (int i = 0; i < 600; i++) begin
      int r = int'($urandom_range(0, 9));
      step("R9", ($urandom_range(0, 3) != 0), (r < 5) ? 0 : int'($urandom_range(0, NQ-1)),
           ($urandom_range(0, 2) == 0), int'($urandom_range(0, NQ-1)));
    end
    for (int q = 0; q < NQ; q++)
      for (int i = 0; i < PRIV + SHR; i++) step("R6", 0, 0, 1, q);

    @(negedge clk);
    enq_valid = 0; deq_valid = 0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule